// File: doc/BRIEF.md
# Privileged Fast-Return State Update Unit

This block performs the architectural state change of a fast return from kernel code at privilege level 0 to user code at privilege level 3. Software first loads a base selector into the unit's model-specific register through a small write/read port. When the execute strobe fires, the unit reads that register, the current privilege level, the operating mode and the two general-purpose values that carry the user instruction pointer and the user stack pointer.

Every new value comes from fixed rules, so no descriptor is fetched from memory. The user code selector is the base plus 16. The user stack selector is the base plus 24. Both selectors have their requested-privilege bits forced to 3. The two descriptor caches take fixed flat attributes. When the preconditions do not hold, the unit raises a general-protection fault pulse and keeps all of its state as it was.

All results are registered. They appear on the clock edge that samples the strobe, together with a one-cycle `done` or `gp_fault` pulse.

Top module: `priv_return_unit`

## Requirements
- R1: Synchronous active-high reset clears the base selector register, `cpl_out`, both selectors, `eip`, `esp` and both descriptor caches to zero, and holds `done` and `gp_fault` low.
- R2: When `cfg_we` is high at a clock edge, the base selector register takes `cfg_wdata` at that edge, and `cfg_rdata` then shows the stored value.
- R3: After a successful return, `cs_sel` equals (base + 16) modulo 2^16 with bits [1:0] forced to 3.
- R4: After a successful return, `ss_sel` equals (base + 24) modulo 2^16 with bits [1:0] forced to 3.
- R5: After a successful return, `eip` holds the `edx_in` value and `esp` holds the `ecx_in` value that were sampled with the strobe.
- R6: A successful return sets `cpl_out` to 3 and raises `done` for exactly the one cycle that follows the strobe edge.
- R7: After a successful return, `cs_desc` is {base 32'h0, limit 32'hFFFF_FFFF, attributes 12'hF97}. The attribute bits are: 0 present, 1 accessed, 2 readable, 3 writable, 4 executable, 5 conforming, 6 expand-down, 7 32-bit, 9:8 DPL, 10 code segment, 11 page granularity. For the code segment this means executable, readable, accessed, non-conforming, DPL 3.
- R8: After a successful return, `ss_desc` is {32'h0, 32'hFFFF_FFFF, 12'hB8F}. With the same bit layout as R7, this means a flat 32-bit data segment that is expand-up, readable, writable and accessed, with DPL 3.
- R9: A strobe with `cpl_in` not equal to 0 faults.
- R10: A strobe with `mode_in` equal to 2'b00 (real-address) faults. The other codes, 2'b01 protected, 2'b10 virtual-8086 and 2'b11 other, do not fault on mode alone.
- R11: A strobe while the base selector register is zero faults.
- R12: On a fault, `gp_fault` pulses for one cycle, `done` stays low, and `cs_sel`, `ss_sel`, `eip`, `esp`, both descriptor caches and `cpl_out` keep their previous values.
- R13: Without a strobe, no pulse is raised and the architectural outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the base selector register |
| cfg_wdata | input | SEL_W | Value to store in the base selector register |
| cfg_rdata | output | SEL_W | Current base selector register value |
| exec_stb | input | 1 | One-cycle execute strobe |
| cpl_in | input | 2 | Current privilege level of the issuing code |
| mode_in | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual-8086, 11 other |
| edx_in | input | PTR_W | Target user instruction pointer |
| ecx_in | input | PTR_W | Target user stack pointer |
| cs_sel | output | SEL_W | Code segment selector |
| ss_sel | output | SEL_W | Stack segment selector |
| eip | output | PTR_W | Instruction pointer |
| esp | output | PTR_W | Stack pointer |
| cs_desc | output | 2*PTR_W+12 | Cached code descriptor {base, limit, attributes} |
| ss_desc | output | 2*PTR_W+12 | Cached stack descriptor {base, limit, attributes} |
| cpl_out | output | 2 | Privilege level after the last update |
| done | output | 1 | One-cycle pulse for a successful return |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
The assertions assume that `exec_stb` is a single-cycle pulse. They also assume that `edx_in`, `ecx_in`, `cpl_in` and `mode_in` are valid in the cycle the strobe is sampled, because the checks compare the results with the values those inputs had one cycle earlier. The bench drives every input on the falling edge. It raises the strobe for exactly one cycle and leaves at least one idle cycle between strobes, and it writes the base register in a cycle with no strobe. Under these conditions the one-cycle look-back in the properties always lands on the strobe cycle.

// File: rtl/priv_return_pkg.sv
package priv_return_pkg;

    localparam int SEL_W_DEF = 16;
    localparam int PTR_W_DEF = 32;
    localparam int ATTR_W    = 12;
    localparam int CODE_OFS  = 16;
    localparam int STACK_OFS = 24;
    localparam logic [1:0] USER_RING   = 2'd3;
    localparam logic [1:0] KERNEL_RING = 2'd0;

    typedef enum logic [1:0] {
        MODE_REAL  = 2'b00,
        MODE_PROT  = 2'b01,
        MODE_V86   = 2'b10,
        MODE_OTHER = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        CHK_IDLE,
        CHK_PASS,
        CHK_FAULT
    } chk_result_e;

    // Attribute word of a cached descriptor, bit 11 first.
    typedef struct packed {
        logic       gran_page;
        logic       is_code;
        logic [1:0] dpl;
        logic       big;
        logic       exp_down;
        logic       conforming;
        logic       exec;
        logic       write;
        logic       read;
        logic       accessed;
        logic       present;
    } seg_attr_t;

    function automatic seg_attr_t flat_code_attr();
        seg_attr_t a;
        a            = '0;
        a.gran_page  = 1'b1;
        a.is_code    = 1'b1;
        a.dpl        = USER_RING;
        a.big        = 1'b1;
        a.exp_down   = 1'b0;
        a.conforming = 1'b0;
        a.exec       = 1'b1;
        a.write      = 1'b0;
        a.read       = 1'b1;
        a.accessed   = 1'b1;
        a.present    = 1'b1;
        return a;
    endfunction

    function automatic seg_attr_t flat_stack_attr();
        seg_attr_t a;
        a            = '0;
        a.gran_page  = 1'b1;
        a.is_code    = 1'b0;
        a.dpl        = USER_RING;
        a.big        = 1'b1;
        a.exp_down   = 1'b0;
        a.conforming = 1'b0;
        a.exec       = 1'b0;
        a.write      = 1'b1;
        a.read       = 1'b1;
        a.accessed   = 1'b1;
        a.present    = 1'b1;
        return a;
    endfunction

endpackage

// File: rtl/base_sel_reg.sv
module base_sel_reg #(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/ret_guard.sv
module ret_guard
    import priv_return_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             exec_stb,
    input  logic [1:0]       cpl_in,
    input  logic [1:0]       mode_in,
    input  logic [SEL_W-1:0] base_sel,
    output chk_result_e      result
);
    op_mode_e mode;
    logic     ring_bad;
    logic     mode_bad;
    logic     base_bad;

    always_comb begin
        mode     = op_mode_e'(mode_in);
        ring_bad = (cpl_in != KERNEL_RING);
        mode_bad = (mode == MODE_REAL);
        base_bad = (base_sel == '0);
        if (!exec_stb)
            result = CHK_IDLE;
        else if (ring_bad || mode_bad || base_bad)
            result = CHK_FAULT;
        else
            result = CHK_PASS;
    end
endmodule

// File: rtl/ret_target_gen.sv
module ret_target_gen
    import priv_return_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int PTR_W = 32,
    localparam int DESC_W = 2*PTR_W + ATTR_W
) (
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [PTR_W-1:0]  edx_in,
    input  logic [PTR_W-1:0]  ecx_in,
    output logic [SEL_W-1:0]  cs_nxt,
    output logic [SEL_W-1:0]  ss_nxt,
    output logic [PTR_W-1:0]  eip_nxt,
    output logic [PTR_W-1:0]  esp_nxt,
    output logic [DESC_W-1:0] cs_desc_nxt,
    output logic [DESC_W-1:0] ss_desc_nxt
);
    localparam int NSEG = 2;

    logic [SEL_W-1:0]  sel_q  [NSEG];
    logic [DESC_W-1:0] desc_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int        OFS  = (g == 0) ? CODE_OFS : STACK_OFS;
        localparam seg_attr_t ATTR = (g == 0) ? flat_code_attr() : flat_stack_attr();
        logic [SEL_W-1:0] sum;
        always_comb begin
            sum      = base_sel + SEL_W'(OFS);
            sel_q[g] = {sum[SEL_W-1:2], USER_RING};
            desc_q[g] = {{PTR_W{1'b0}}, {PTR_W{1'b1}}, ATTR};
        end
    end

    assign cs_nxt      = sel_q[0];
    assign ss_nxt      = sel_q[1];
    assign cs_desc_nxt = desc_q[0];
    assign ss_desc_nxt = desc_q[1];
    assign eip_nxt     = edx_in;
    assign esp_nxt     = ecx_in;
endmodule

// File: rtl/priv_return_unit.sv
module priv_return_unit
    import priv_return_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF,
    parameter int PTR_W = PTR_W_DEF,
    localparam int DESC_W = 2*PTR_W + ATTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_wdata,
    output logic [SEL_W-1:0]  cfg_rdata,
    input  logic              exec_stb,
    input  logic [1:0]        cpl_in,
    input  logic [1:0]        mode_in,
    input  logic [PTR_W-1:0]  edx_in,
    input  logic [PTR_W-1:0]  ecx_in,
    output logic [SEL_W-1:0]  cs_sel,
    output logic [SEL_W-1:0]  ss_sel,
    output logic [PTR_W-1:0]  eip,
    output logic [PTR_W-1:0]  esp,
    output logic [DESC_W-1:0] cs_desc,
    output logic [DESC_W-1:0] ss_desc,
    output logic [1:0]        cpl_out,
    output logic              done,
    output logic              gp_fault
);
    typedef struct packed {
        logic [SEL_W-1:0]  cs;
        logic [SEL_W-1:0]  ss;
        logic [PTR_W-1:0]  ip;
        logic [PTR_W-1:0]  sp;
        logic [DESC_W-1:0] cs_d;
        logic [DESC_W-1:0] ss_d;
        logic [1:0]        ring;
    } arch_state_t;

    logic [SEL_W-1:0] base_sel;
    chk_result_e      result;
    arch_state_t      st_q;
    arch_state_t      st_nxt;

    base_sel_reg #(.SEL_W(SEL_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (base_sel)
    );

    ret_guard #(.SEL_W(SEL_W)) u_guard (
        .exec_stb (exec_stb),
        .cpl_in   (cpl_in),
        .mode_in  (mode_in),
        .base_sel (base_sel),
        .result   (result)
    );

    ret_target_gen #(.SEL_W(SEL_W), .PTR_W(PTR_W)) u_gen (
        .base_sel    (base_sel),
        .edx_in      (edx_in),
        .ecx_in      (ecx_in),
        .cs_nxt      (st_nxt.cs),
        .ss_nxt      (st_nxt.ss),
        .eip_nxt     (st_nxt.ip),
        .esp_nxt     (st_nxt.sp),
        .cs_desc_nxt (st_nxt.cs_d),
        .ss_desc_nxt (st_nxt.ss_d)
    );

    assign st_nxt.ring = USER_RING;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            done     <= 1'b0;
            gp_fault <= 1'b0;
        end else begin
            done     <= (result == CHK_PASS);
            gp_fault <= (result == CHK_FAULT);
            if (result == CHK_PASS)
                st_q <= st_nxt;
        end
    end

    assign cfg_rdata = base_sel;
    assign cs_sel    = st_q.cs;
    assign ss_sel    = st_q.ss;
    assign eip       = st_q.ip;
    assign esp       = st_q.sp;
    assign cs_desc   = st_q.cs_d;
    assign ss_desc   = st_q.ss_d;
    assign cpl_out   = st_q.ring;
endmodule

// File: rtl/priv_return_chk.sv
module priv_return_chk #(
    parameter int SEL_W = 16,
    parameter int PTR_W = 32,
    localparam int DESC_W = 2*PTR_W + 12
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  cfg_rdata,
    input logic              exec_stb,
    input logic [1:0]        cpl_in,
    input logic [1:0]        mode_in,
    input logic [PTR_W-1:0]  edx_in,
    input logic [PTR_W-1:0]  ecx_in,
    input logic [SEL_W-1:0]  cs_sel,
    input logic [SEL_W-1:0]  ss_sel,
    input logic [PTR_W-1:0]  eip,
    input logic [PTR_W-1:0]  esp,
    input logic [DESC_W-1:0] cs_desc,
    input logic [DESC_W-1:0] ss_desc,
    input logic [1:0]        cpl_out,
    input logic              done,
    input logic              gp_fault
);
    localparam logic [DESC_W-1:0] CS_FLAT = {{PTR_W{1'b0}}, {PTR_W{1'b1}}, 12'hF97};
    localparam logic [DESC_W-1:0] SS_FLAT = {{PTR_W{1'b0}}, {PTR_W{1'b1}}, 12'hB8F};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cpl_out == 2'd0 && cfg_rdata == '0 && !done && !gp_fault)); // R1

    AST_SEL_GAP: assert property (@(posedge clk) disable iff (rst)
        done |-> (ss_sel == cs_sel + SEL_W'(8))); // R4

    AST_SEL_RPL: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_sel[1:0] == 2'd3 && ss_sel[1:0] == 2'd3)); // R3

    AST_PTR_COPY: assert property (@(posedge clk) disable iff (rst)
        done |-> (eip == $past(edx_in) && esp == $past(ecx_in))); // R5

    AST_USER_RING: assert property (@(posedge clk) disable iff (rst)
        done |-> (cpl_out == 2'd3)); // R6

    AST_CODE_DESC: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_desc == CS_FLAT)); // R7

    AST_STACK_DESC: assert property (@(posedge clk) disable iff (rst)
        done |-> (ss_desc == SS_FLAT)); // R8

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> $past(cpl_in != 2'd0 || mode_in == 2'b00 || cfg_rdata == '0)); // R11

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> ($stable(cs_sel) && $stable(ss_sel) && $stable(eip)
                      && $stable(esp) && $stable(cpl_out))); // R12

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && gp_fault)); // R12

    AST_PULSE_CAUSED: assert property (@(posedge clk) disable iff (rst)
        (done || gp_fault) |-> $past(exec_stb)); // R13
endmodule

bind priv_return_unit priv_return_chk #(.SEL_W(SEL_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .exec_stb  (exec_stb),
    .cpl_in    (cpl_in),
    .mode_in   (mode_in),
    .edx_in    (edx_in),
    .ecx_in    (ecx_in),
    .cs_sel    (cs_sel),
    .ss_sel    (ss_sel),
    .eip       (eip),
    .esp       (esp),
    .cs_desc   (cs_desc),
    .ss_desc   (ss_desc),
    .cpl_out   (cpl_out),
    .done      (done),
    .gp_fault  (gp_fault)
);

// File: tb/test_priv_return_unit.sv
`timescale 1ns/1ps
module test_priv_return_unit;
    localparam int SEL_W  = 16;
    localparam int PTR_W  = 32;
    localparam int DESC_W = 2*PTR_W + 12;
    localparam int NVEC   = 10;
    localparam logic [DESC_W-1:0] CS_FLAT = {32'h0, 32'hFFFF_FFFF, 12'hF97};
    localparam logic [DESC_W-1:0] SS_FLAT = {32'h0, 32'hFFFF_FFFF, 12'hB8F};

    typedef struct packed {
        logic [15:0] base;
        logic [1:0]  cpl;
        logic [1:0]  mode;
        logic [31:0] edx;
        logic [31:0] ecx;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h0010, 2'd0, 2'b01, 32'h0040_1000, 32'hBFFF_F000},
        '{16'h0008, 2'd3, 2'b01, 32'h1111_1111, 32'h2222_2222},
        '{16'h0060, 2'd0, 2'b00, 32'h3333_3333, 32'h4444_4444},
        '{16'h0000, 2'd0, 2'b01, 32'h5555_5555, 32'h6666_6666},
        '{16'hFFF0, 2'd0, 2'b10, 32'h0804_8000, 32'h7FFF_FFFC},
        '{16'h1234, 2'd0, 2'b11, 32'hDEAD_BEEF, 32'hCAFE_F00D},
        '{16'h0020, 2'd1, 2'b01, 32'h7777_7777, 32'h8888_8888},
        '{16'h0073, 2'd0, 2'b01, 32'h0000_0000, 32'hFFFF_FFFF},
        '{16'hFFE8, 2'd0, 2'b01, 32'hFFFF_FFFF, 32'h0000_0000},
        '{16'h0040, 2'd2, 2'b00, 32'h9999_9999, 32'hAAAA_AAAA}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [SEL_W-1:0]  cfg_wdata = '0;
    logic [SEL_W-1:0]  cfg_rdata;
    logic              exec_stb = 1'b0;
    logic [1:0]        cpl_in = 2'd0;
    logic [1:0]        mode_in = 2'b01;
    logic [PTR_W-1:0]  edx_in = '0;
    logic [PTR_W-1:0]  ecx_in = '0;
    logic [SEL_W-1:0]  cs_sel, ss_sel;
    logic [PTR_W-1:0]  eip, esp;
    logic [DESC_W-1:0] cs_desc, ss_desc;
    logic [1:0]        cpl_out;
    logic              done, gp_fault;

    int total = 0;
    int bad   = 0;

    // Model of the architectural state
    logic [15:0] m_cs = '0, m_ss = '0;
    logic [31:0] m_ip = '0, m_sp = '0;
    logic [DESC_W-1:0] m_csd = '0, m_ssd = '0;
    logic [1:0]  m_cpl = '0;

    always #4 clk = ~clk;

    priv_return_unit #(.SEL_W(SEL_W), .PTR_W(PTR_W)) i_priv_return_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .exec_stb(exec_stb), .cpl_in(cpl_in),
        .mode_in(mode_in), .edx_in(edx_in), .ecx_in(ecx_in),
        .cs_sel(cs_sel), .ss_sel(ss_sel), .eip(eip), .esp(esp),
        .cs_desc(cs_desc), .ss_desc(ss_desc), .cpl_out(cpl_out),
        .done(done), .gp_fault(gp_fault)
    );

    task automatic check(input string tag, input logic [DESC_W-1:0] act,
                         input logic [DESC_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " cs_sel"},  DESC_W'(cs_sel),  DESC_W'(m_cs));
        check({tag, " ss_sel"},  DESC_W'(ss_sel),  DESC_W'(m_ss));
        check({tag, " eip"},     DESC_W'(eip),     DESC_W'(m_ip));
        check({tag, " esp"},     DESC_W'(esp),     DESC_W'(m_sp));
        check({tag, " cs_desc"}, cs_desc,          m_csd);
        check({tag, " ss_desc"}, ss_desc,          m_ssd);
        check({tag, " cpl_out"}, DESC_W'(cpl_out), DESC_W'(m_cpl));
    endtask

    function automatic logic [15:0] user_sel(input logic [15:0] b, input int ofs);
        logic [15:0] s;
        s = b + 16'(ofs);
        return s | 16'h0003;
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic flt;
        @(negedge clk);
        cycle();
        rst = 1'b0;
        // R1: reset state
        check("R1 base", DESC_W'(cfg_rdata), '0);
        check("R1 done", DESC_W'(done), '0);
        check("R1 fault", DESC_W'(gp_fault), '0);
        check_state("R1");

        for (int i = 0; i < NVEC; i++) begin
            cfg_we = 1'b1;
            cfg_wdata = VECS[i].base;
            cycle();
            cfg_we = 1'b0;
            check("R2 readback", DESC_W'(cfg_rdata), DESC_W'(VECS[i].base));

            cpl_in  = VECS[i].cpl;
            mode_in = VECS[i].mode;
            edx_in  = VECS[i].edx;
            ecx_in  = VECS[i].ecx;
            exec_stb = 1'b1;
            cycle();
            exec_stb = 1'b0;

            flt = (VECS[i].cpl != 2'd0) || (VECS[i].mode == 2'b00) || (VECS[i].base == 16'h0);
            if (!flt) begin
                m_cs  = user_sel(VECS[i].base, 16);
                m_ss  = user_sel(VECS[i].base, 24);
                m_ip  = VECS[i].edx;
                m_sp  = VECS[i].ecx;
                m_csd = CS_FLAT;
                m_ssd = SS_FLAT;
                m_cpl = 2'd3;
                check("R6 done", DESC_W'(done), 1);
                check("R12 no fault on pass", DESC_W'(gp_fault), 0);
                check_state("R3 R4 R5 R7 R8 pass");
            end else begin
                if (VECS[i].cpl != 2'd0)       check("R9 ring fault", DESC_W'(gp_fault), 1);
                else if (VECS[i].mode == 2'b00) check("R10 mode fault", DESC_W'(gp_fault), 1);
                else                            check("R11 base fault", DESC_W'(gp_fault), 1);
                check("R12 done low", DESC_W'(done), 0);
                check_state("R12 state kept");
            end

            // Idle cycle with new GPR values: nothing moves
            edx_in = ~VECS[i].edx;
            ecx_in = ~VECS[i].ecx;
            cycle();
            check("R6 R12 pulse ends", DESC_W'({done, gp_fault}), 0);
            check_state("R13 idle");
        end

        // Mid-run reset
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        m_cs = '0; m_ss = '0; m_ip = '0; m_sp = '0;
        m_csd = '0; m_ssd = '0; m_cpl = '0;
        check("R1 base after reset", DESC_W'(cfg_rdata), '0);
        check_state("R1 after reset");

        // Strobe right after reset: base is zero
        cpl_in = 2'd0;
        mode_in = 2'b01;
        exec_stb = 1'b1;
        cycle();
        exec_stb = 1'b0;
        check("R11 zero base after reset", DESC_W'(gp_fault), 1);
        check_state("R12 after zero-base fault");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule